// File: doc/BRIEF.md
# Serial-Programmed Eight-Bit I/O Port

This block is a general-purpose port of eight pins controlled over a four-wire serial link in mode 0. The link uses an active-low select, a serial clock, a data-in line and a tri-stated data-out line. Each pin can be an input or an output, set by a direction register. A data register holds the output levels. A compare unit reports a single flag that says whether the pins agree with the data register in a chosen way. All serial inputs are sampled by the system clock through a synchronizer and their edges are detected in the clock domain.

Every transfer starts with a control byte and continues with one data byte, most significant bit first. Two hardwired identity inputs let up to four ports share one select line. Only the port whose identity matches the first two control bits takes part in the transfer. A write can load a register directly, or it can use the data byte as a mask to set or clear chosen bits without touching the others. While the control byte is shifting in, a selected port returns the compare flag. The flag is captured at the moment the select goes low.

Top module: `sio_port`

## Requirements
- R1: `pin_oe` equals the direction register and `pin_out` equals the data register. A direction bit of 1 makes that pin an output and a 0 makes it an input.
- R2: A read of the data register returns `pin_in` for bits whose direction is 0 and the stored data bit for bits whose direction is 1. A read of the direction register returns the direction register.
- R3: After reset the direction register is 0 (all pins are inputs), the data register is 0, the compare mode is 00, the flag is 0 and `miso_oe` is 0.
- R4: Control bit 7 is compared with `chip_id[1]` and control bit 6 with `chip_id[0]`. On a mismatch the port ignores the rest of the transfer: no register changes, no mode change, and `miso_oe` stays 0.
- R5: The control byte is sent bit 7 first. Bit 5 chooses write (1) or read (0). Bit 4 chooses the data register (1) or the direction register (0). Bits 3:2 are the write format, and bits 1:0 are the compare mode.
- R6: Write format 0x (bit 3 = 0) loads the data byte into the register. Format 10 clears every bit whose mask bit is 1. Format 11 sets every bit whose mask bit is 1. Bits whose mask bit is 0 keep their value. For example, starting from 0xAA with data 0xF0, the three formats give 0xF0, 0x0A and 0xFA.
- R7: The compare flag is 1 under these conditions, and 0 otherwise:
  - mode 00: at least one bit mismatches;
  - mode 01: every bit matches;
  - mode 10: every bit mismatches;
  - mode 11: at least one bit matches.
- R8: In the compare, an input bit matches when `pin_in` equals the data register bit. An output bit always counts as a match.
- R9: The flag is captured on the falling edge of `cs_n`. Later pin changes during the transfer do not alter it. A selected port drives the flag on `miso` before control bits 5 down to 0 are sampled.
- R10: `miso_oe` is 0 while `cs_n` is high. During a read data byte it is 1 and `miso` carries the read value, MSB first, valid before each rising SCK edge. During a write data byte it is 0.
- R11: The compare mode changes only when a complete control byte with a matching identity is received. A transfer cut short inside the control byte leaves the mode unchanged.
- R12: A read does not change any register. A write whose data byte is cut short by `cs_n` rising does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select shared by up to four ports |
| sck | input | 1 | Serial clock, idle low, data sampled on the rise |
| mosi | input | 1 | Serial data into the port |
| miso | output | 1 | Serial data out of the port |
| miso_oe | output | 1 | Drive enable for `miso`; 0 means high impedance |
| chip_id | input | 2 | Hardwired identity of this port |
| pin_in | input | PORT_W | Levels seen on the port pins |
| pin_out | output | PORT_W | Levels driven on the port pins |
| pin_oe | output | PORT_W | Per-pin output enable |

## Verification
The bench builds the port with its defaults: eight pins and two synchronizer stages. `chip_id` is tied to 10, and the serial clock half-period is six system clocks, so every synchronized edge settles well before the next one. Eight pins keep the all-match and all-mismatch compare conditions reachable under random pin levels and random direction masks. The two identity bits make roughly one transfer in four a foreign one, which exercises ignored transfers. Directed transfers cover the worked mask examples, a pin change after select assertion, and transfers cut short in each byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int CTRL_W = 8;
    localparam int ID_W   = 2;

    typedef enum logic [1:0] {
        CMP_ANY_DIFF = 2'b00,
        CMP_ALL_SAME = 2'b01,
        CMP_ALL_DIFF = 2'b10,
        CMP_ANY_SAME = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            wr;
        logic            sel_data;
        logic            fmt_mask;
        logic            fmt_set;
        cmp_mode_e       cm;
    } ctrl_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int         N       = 1,
    parameter int         STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [N-1:0] stg_d;
        if (g == 0) begin : g_first
            assign stg_d = d;
        end else begin : g_next
            assign stg_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sio_link.sv
module sio_link
    import sio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [ID_W-1:0]   chip_id,
    input  logic              flag,
    input  logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] rd_dir,
    output logic              cs_fall,
    output logic              ctrl_vld,
    output logic              wr_vld,
    output logic              sel_data,
    output logic              fmt_mask,
    output logic              fmt_set,
    output logic [1:0]        cm,
    output logic [PORT_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe
);
    localparam int MAXB  = (PORT_W > CTRL_W) ? PORT_W : CTRL_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    typedef enum logic [1:0] {LK_IDLE, LK_CTRL, LK_DATA, LK_DONE} link_st_e;

    typedef struct packed {
        link_st_e            st;
        logic [CNT_W-1:0]    cnt;
        logic [CTRL_W-1:0]   csh;
        logic [PORT_W-1:0]   dsh;
        logic [PORT_W-1:0]   rsh;
        ctrl_t               ctrl;
        logic                ctrl_vld;
        logic                wr_vld;
        logic                sck_p;
        logic                cs_p;
    } link_t;

    link_t lk_q, lk_d;
    logic  sck_rise;

    always_comb begin
        lk_d          = lk_q;
        lk_d.ctrl_vld = 1'b0;
        lk_d.wr_vld   = 1'b0;
        lk_d.sck_p    = sck_s;
        lk_d.cs_p     = cs_n_s;
        sck_rise      = sck_s & ~lk_q.sck_p;
        if (cs_n_s) begin
            lk_d.st  = LK_IDLE;
            lk_d.cnt = '0;
        end else begin
            case (lk_q.st)
                LK_IDLE: begin
                    lk_d.st  = LK_CTRL;
                    lk_d.cnt = '0;
                end
                LK_CTRL: if (sck_rise) begin
                    lk_d.csh = {lk_q.csh[CTRL_W-2:0], mosi_s};
                    lk_d.cnt = lk_q.cnt + 1'b1;
                    if (lk_d.cnt == CNT_W'(ID_W) && lk_d.csh[ID_W-1:0] != chip_id) begin
                        lk_d.st = LK_DONE;
                    end else if (lk_d.cnt == CNT_W'(CTRL_W)) begin
                        lk_d.ctrl     = ctrl_t'(lk_d.csh);
                        lk_d.ctrl_vld = 1'b1;
                        lk_d.st       = LK_DATA;
                        lk_d.cnt      = '0;
                        lk_d.rsh      = lk_d.ctrl.sel_data ? rd_data : rd_dir;
                    end
                end
                LK_DATA: if (sck_rise) begin
                    lk_d.dsh = {lk_q.dsh[PORT_W-2:0], mosi_s};
                    lk_d.rsh = {lk_q.rsh[PORT_W-2:0], 1'b0};
                    lk_d.cnt = lk_q.cnt + 1'b1;
                    if (lk_d.cnt == CNT_W'(PORT_W)) begin
                        lk_d.st     = LK_DONE;
                        lk_d.wr_vld = lk_q.ctrl.wr;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q       <= '0;
            lk_q.st    <= LK_IDLE;
            lk_q.cs_p  <= 1'b1;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign cs_fall  = lk_q.cs_p & ~cs_n_s;
    assign ctrl_vld = lk_q.ctrl_vld;
    assign wr_vld   = lk_q.wr_vld;
    assign sel_data = lk_q.ctrl.sel_data;
    assign fmt_mask = lk_q.ctrl.fmt_mask;
    assign fmt_set  = lk_q.ctrl.fmt_set;
    assign cm       = lk_q.ctrl.cm;
    assign wr_data  = lk_q.dsh;
    assign miso_oe  = (lk_q.st == LK_CTRL && lk_q.cnt >= CNT_W'(ID_W))
                    || (lk_q.st == LK_DATA && !lk_q.ctrl.wr);
    assign miso     = (lk_q.st == LK_CTRL) ? flag : lk_q.rsh[PORT_W-1];

    // R10: no drive once select has been high for two samples
    assert_hiz_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !miso_oe);

    // R5: control completion, data completion and select edge never coincide
    assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_vld, wr_vld, cs_fall}));

    // R12: a register write only follows a completed data byte with select low
    assert_wr_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> $past(!cs_n_s));
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              ctrl_vld,
    input  logic              wr_vld,
    input  logic              sel_data,
    input  logic              fmt_mask,
    input  logic              fmt_set,
    input  logic [1:0]        cm,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] dir,
    output logic [PORT_W-1:0] data,
    output logic              flag,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] rd_dir
);
    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
        cmp_mode_e         cm;
        logic              flag;
    } regs_t;

    regs_t rg_q, rg_d;
    logic [PORT_W-1:0] mism;
    logic [PORT_W-1:0] tgt;
    logic [PORT_W-1:0] upd;
    logic              hit;

    always_comb begin
        rg_d = rg_q;
        mism = (pin_in ^ rg_q.data) & ~rg_q.dir;
        case (rg_q.cm)
            CMP_ANY_DIFF: hit = |mism;
            CMP_ALL_SAME: hit = ~|mism;
            CMP_ALL_DIFF: hit = &mism;
            default:      hit = ~&mism;
        endcase
        tgt = sel_data ? rg_q.data : rg_q.dir;
        if (!fmt_mask)     upd = wr_data;
        else if (fmt_set)  upd = tgt | wr_data;
        else               upd = tgt & ~wr_data;
        if (cs_fall)  rg_d.flag = hit;
        if (ctrl_vld) rg_d.cm   = cmp_mode_e'(cm);
        if (wr_vld) begin
            if (sel_data) rg_d.data = upd;
            else          rg_d.dir  = upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q    <= '0;
            rg_q.cm <= CMP_ANY_DIFF;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign dir     = rg_q.dir;
    assign data    = rg_q.data;
    assign flag    = rg_q.flag;
    assign rd_data = (pin_in & ~rg_q.dir) | (rg_q.data & rg_q.dir);
    assign rd_dir  = rg_q.dir;

    assert_reset_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dir == '0 && data == '0 && !flag));

    assert_hold_no_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> ($stable(dir) && $stable(data)));

    assert_set_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && fmt_mask && fmt_set && sel_data) |=> ((data & $past(wr_data)) == $past(wr_data)));

    assert_clr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && fmt_mask && !fmt_set && !sel_data) |=> ((dir & $past(wr_data)) == '0));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(flag));

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_vld |=> $stable(rg_q.cm));

    assert_out_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && dir == '1 && rg_q.cm == CMP_ALL_SAME) |=> flag);
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic [2:0]        ser_s;
    logic              cs_fall, ctrl_vld, wr_vld, sel_data, fmt_mask, fmt_set, flag;
    logic [1:0]        cm;
    logic [PORT_W-1:0] wr_data, rd_data, rd_dir, dir, data;

    sio_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, mosi}),
        .q     (ser_s)
    );

    sio_link #(.PORT_W(PORT_W)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (ser_s[2]),
        .sck_s    (ser_s[1]),
        .mosi_s   (ser_s[0]),
        .chip_id  (chip_id),
        .flag     (flag),
        .rd_data  (rd_data),
        .rd_dir   (rd_dir),
        .cs_fall  (cs_fall),
        .ctrl_vld (ctrl_vld),
        .wr_vld   (wr_vld),
        .sel_data (sel_data),
        .fmt_mask (fmt_mask),
        .fmt_set  (fmt_set),
        .cm       (cm),
        .wr_data  (wr_data),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    sio_regfile #(.PORT_W(PORT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .ctrl_vld (ctrl_vld),
        .wr_vld   (wr_vld),
        .sel_data (sel_data),
        .fmt_mask (fmt_mask),
        .fmt_set  (fmt_set),
        .cm       (cm),
        .wr_data  (wr_data),
        .pin_in   (pin_in),
        .dir      (dir),
        .data     (data),
        .flag     (flag),
        .rd_data  (rd_data),
        .rd_dir   (rd_dir)
    );

    assign pin_out = data;
    assign pin_oe  = dir;
endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
    localparam int         H     = 6;
    localparam logic [1:0] MY_ID = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] dir_m = 8'h00, data_m = 8'h00;
    logic [1:0] cm_m = 2'b00;

    always #2 clk = ~clk;

    sio_port u_sio_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .chip_id(MY_ID),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic exp_flag(logic [1:0] m, logic [7:0] d, logic [7:0] v, logic [7:0] p);
        logic [7:0] diff;
        diff = (p ^ v) & ~d;
        case (m)
            2'b00:   return diff != 8'h00;
            2'b01:   return diff == 8'h00;
            2'b10:   return diff == 8'hFF;
            default: return diff != 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_wr(logic [7:0] old, logic [7:0] m, logic f1, logic f0);
        if (!f1) return m;
        return f0 ? (old | m) : (old & ~m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                        input logic chg, input logic [7:0] newp,
                        output logic [15:0] mv, output logic [15:0] ov);
        logic [15:0] word;
        word = {c, d};
        mv = '0;
        ov = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        if (chg) pin_in = newp;
        for (int i = 0; i < nbits; i++) begin
            mosi = word[15-i];
            repeat (H) @(negedge clk);
            mv[15-i] = miso;
            ov[15-i] = miso_oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic do_tx(input logic [7:0] c, input logic [7:0] d, input int nbits,
                         input logic chg, input logic [7:0] newp);
        logic [15:0] mv, ov;
        logic        id_ok, f;
        logic [7:0]  p_rd, rd_exp;
        id_ok = (c[7:6] == MY_ID);
        f     = exp_flag(cm_m, dir_m, data_m, pin_in);
        p_rd  = chg ? newp : pin_in;
        rd_exp = c[4] ? ((p_rd & ~dir_m) | (data_m & dir_m)) : dir_m;
        xfer(c, d, nbits, chg, newp, mv, ov);
        if (nbits == 16) begin
            chk("R4 id bits undriven", 32'(ov[15:14]), 32'h0);
            if (id_ok) begin
                chk("R9 flag drive enable", 32'(ov[13:8]), 32'h3F);
                chk("R7 R9 flag value", 32'(mv[13:8]), f ? 32'h3F : 32'h0);
                if (!c[5]) begin
                    chk("R10 read enable", 32'(ov[7:0]), 32'hFF);
                    chk("R2 read value", 32'(mv[7:0]), 32'(rd_exp));
                end else begin
                    chk("R10 write byte undriven", 32'(ov[7:0]), 32'h0);
                end
            end else begin
                chk("R4 foreign id undriven", 32'(ov), 32'h0);
            end
        end
        if (id_ok && nbits >= 8) cm_m = c[1:0];
        if (id_ok && nbits == 16 && c[5]) begin
            if (c[4]) data_m = exp_wr(data_m, d, c[3], c[2]);
            else      dir_m  = exp_wr(dir_m, d, c[3], c[2]);
        end
        chk("R1 pin_oe", 32'(pin_oe), 32'(dir_m));
        chk("R1 pin_out", 32'(pin_out), 32'(data_m));
        chk("R10 idle undriven", 32'(miso_oe), 32'h0);
    endtask

    function automatic logic [7:0] cb(logic w, logic s, logic [1:0] fm, logic [1:0] m);
        return {MY_ID, w, s, fm, m};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        chk("R3 reset pin_oe", 32'(pin_oe), 32'h0);
        chk("R3 reset pin_out", 32'(pin_out), 32'h0);
        chk("R3 reset miso_oe", 32'(miso_oe), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R3: reset mode 00 with flag 0; pins equal data so no mismatch
        do_tx(cb(1'b0, 1'b0, 2'b00, 2'b00), 8'h00, 16, 1'b0, 8'h00);

        // R6 worked examples on the data register with all pins outputs
        do_tx(cb(1'b1, 1'b0, 2'b00, 2'b00), 8'hFF, 16, 1'b0, 8'h00);
        do_tx(cb(1'b1, 1'b1, 2'b00, 2'b00), 8'hAA, 16, 1'b0, 8'h00);
        do_tx(cb(1'b1, 1'b1, 2'b11, 2'b00), 8'hF0, 16, 1'b0, 8'h00);
        chk("R6 set mask", 32'(pin_out), 32'hFA);
        do_tx(cb(1'b1, 1'b1, 2'b00, 2'b00), 8'hAA, 16, 1'b0, 8'h00);
        do_tx(cb(1'b1, 1'b1, 2'b10, 2'b00), 8'hF0, 16, 1'b0, 8'h00);
        chk("R6 clear mask", 32'(pin_out), 32'h0A);
        do_tx(cb(1'b1, 1'b1, 2'b01, 2'b10), 8'hF0, 16, 1'b0, 8'h00);
        chk("R6 direct write", 32'(pin_out), 32'hF0);

        // R8: all outputs, mode 10 (all mismatch) gives flag 0
        pin_in = 8'h0F;
        do_tx(cb(1'b0, 1'b1, 2'b00, 2'b10), 8'h00, 16, 1'b0, 8'h00);

        // R12: aborted write data byte leaves registers untouched
        do_tx(cb(1'b1, 1'b1, 2'b00, 2'b01), 8'h00, 12, 1'b0, 8'h00);
        chk("R12 aborted write", 32'(pin_out), 32'hF0);
        // R11: aborted control byte keeps mode 01
        do_tx(cb(1'b0, 1'b0, 2'b00, 2'b11), 8'h00, 5, 1'b0, 8'h00);
        do_tx(cb(1'b1, 1'b0, 2'b00, 2'b01), 8'h00, 16, 1'b0, 8'h00);
        // R9: flag held against a pin change after select assertion
        pin_in = 8'h00;
        do_tx(cb(1'b0, 1'b1, 2'b00, 2'b01), 8'h00, 16, 1'b1, 8'h3C);
        // R4: foreign identity write ignored
        do_tx({2'b01, 1'b1, 1'b1, 2'b00, 2'b00}, 8'h55, 16, 1'b0, 8'h00);
        chk("R4 foreign write ignored", 32'(pin_out), 32'hF0);

        for (int n = 0; n < 200; n++) begin
            logic [7:0] c;
            int nb;
            c = 8'($urandom);
            if ($urandom % 4 != 0) c[7:6] = MY_ID;
            nb = ($urandom % 16 == 0) ? 1 + int'($urandom % 15) : 16;
            pin_in = 8'($urandom);
            do_tx(c, 8'($urandom), nb, 1'b0, 8'h00);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule